// File: doc/BRIEF.md
# Single and Double Word Shifter

This block is the shifting datapath of a register-to-register execution stage. It takes one 16-bit register operand, or a 32-bit operand built from register r and the register after it, and returns the shifted value for write-back to the same register or registers. A 4-bit operation code selects the direction, the width and the fill policy. The fill policy is zero fill, one fill, edge-bit extend or circular rotation. A count input gives the shift distance.

The block also performs the clear pseudo-operation, which is carried out as a 16-bit right zero-fill shift of a single register. It works out the index of the partner register, wrapping from 15 back to 0. It checks the count against the legal range for the selected width. On an illegal count it raises an error and asserts no write enable, so the register file is left untouched. The datapath is purely combinational, and results are valid in the same cycle as the operands.

Top module: `reg_shift_unit`

## Requirements
- R1: The operation code is decoded as follows. Bit 3 gives direction (0 right, 1 left). Bit 2 gives width (0 single, 1 double). Bits 1:0 give fill (00 zero, 01 one, 10 extend, 11 circular).
- R2: A zero-fill shift moves the operand by the count and fills the vacated positions with 0. A single shift of 16 yields 0.
- R3: A one-fill shift fills the vacated positions with 1.
- R4: A right extend shift fills with the original most significant bit. A left extend shift fills with the original least significant bit.
- R5: A circular shift rotates the bits. A rotation by the full width (16 single, 32 double) returns the original value.
- R6: A double shift operates on {opnd_hi, opnd_lo}, where opnd_hi is register r and is the upper half. It returns the halves on res_hi and res_lo, with wr_hi and wr_lo both set.
- R7: pair_idx equals (reg_idx + 1) modulo 16, so register 15 pairs with register 0.
- R8: Legal counts are 1..16 for single shifts and 1..32 for double shifts. Any other count sets cnt_err, clears wr_hi and wr_lo, and passes both operands through unchanged.
- R9: A legal single shift writes only res_hi (wr_hi=1, wr_lo=0), and res_lo equals opnd_lo.
- R10: When clr_req is 1, op_code and count are ignored. The result is res_hi=0 with wr_hi=1, wr_lo=0 and cnt_err=0.
- R11: The outputs follow the inputs combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Direction, width and fill selection |
| reg_idx | input | 4 | Index of register r |
| count | input | 6 | Shift distance |
| clr_req | input | 1 | Clear pseudo-operation request |
| opnd_hi | input | 16 | Contents of register r |
| opnd_lo | input | 16 | Contents of register r+1 |
| res_hi | output | 16 | Write-back value for register r |
| res_lo | output | 16 | Write-back value for register r+1 |
| wr_hi | output | 1 | Write enable for register r |
| wr_lo | output | 1 | Write enable for register r+1 |
| pair_idx | output | 4 | Wrapped index of register r+1 |
| cnt_err | output | 1 | Count out of range for the selected width |

## Verification
Each of the sixteen operations is applied to asymmetric patterns. A single isolated bit at either edge shows direction and fill. A word whose top and bottom bits differ separates right extend from left extend. Alternating patterns expose a rotation that drops or duplicates bits. The counts 0, 1, the width limit and one past it are applied at both widths, which tells the two legal ranges apart and shows that a rejected count leaves no write. A pseudo-random sweep is compared with a bit-at-a-time reference, and the register indices 14 and 15 cover the pair wrap.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_ONE  = 2'b01,
    FILL_EXT  = 2'b10,
    FILL_ROT  = 2'b11
  } fill_e;

  localparam int OP_DIR_BIT = 3;
  localparam int OP_DBL_BIT = 2;
endpackage

// File: rtl/shf_range_chk.sv
module shf_range_chk #(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic          dbl,
  input  logic [CW-1:0] amt,
  output logic          err
);
  localparam int LIM_S = W;
  localparam int LIM_D = 2 * W;

  logic [CW:0] amt_x;

  always_comb begin
    amt_x = {1'b0, amt};
    if (amt == '0) begin
      err = 1'b1;
    end else if (dbl) begin
      err = (amt_x > (CW+1)'(LIM_D));
    end else begin
      err = (amt_x > (CW+1)'(LIM_S));
    end
  end
endmodule

// File: rtl/shf_pair_idx.sv
module shf_pair_idx #(
  parameter int RW = 4
) (
  input  logic [RW-1:0] base_idx,
  output logic [RW-1:0] next_idx
);
  always_comb begin
    next_idx = base_idx + RW'(1);
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]          val,
  input  logic [$clog2(DW):0]    amt,
  input  logic                   left,
  input  fill_e                  fill,
  output logic [DW-1:0]          res
);
  localparam int AW = $clog2(DW) + 1;

  logic [DW-1:0]   fill_vec;
  logic [2*DW-1:0] wide;
  logic            amt_ok;

  always_comb begin
    unique case (fill)
      FILL_ZERO: fill_vec = '0;
      FILL_ONE:  fill_vec = '1;
      FILL_EXT:  fill_vec = left ? {DW{val[0]}} : {DW{val[DW-1]}};
      default:   fill_vec = val;
    endcase

    if (left) begin
      wide = {val, fill_vec} << amt;
      res  = wide[2*DW-1:DW];
    end else begin
      wide = {fill_vec, val} >> amt;
      res  = wide[DW-1:0];
    end

    amt_ok = (amt != '0) && ({1'b0, amt} <= (AW+1)'(DW));

    // R5
    if (amt_ok && fill == FILL_ROT) begin
      rot_keeps_ones_chk: assert ($countones(res) == $countones(val))
        else $error("rotation changed the number of set bits");
    end
    // R2
    if (fill == FILL_ZERO && {1'b0, amt} == (AW+1)'(DW)) begin
      zero_full_clear_chk: assert (res == '0)
        else $error("full-width zero fill left bits set");
    end
    // R3
    if (fill == FILL_ONE && {1'b0, amt} == (AW+1)'(DW)) begin
      one_full_set_chk: assert (res == '1)
        else $error("full-width one fill left bits clear");
    end
    // R4
    if (amt_ok && fill == FILL_EXT && !left) begin
      ext_right_msb_chk: assert (res[DW-1] == val[DW-1])
        else $error("right extend lost the sign bit");
    end
    // R4
    if (amt_ok && fill == FILL_EXT && left) begin
      ext_left_lsb_chk: assert (res[0] == val[0])
        else $error("left extend lost the low bit");
    end
  end
endmodule

// File: rtl/reg_shift_unit.sv
module reg_shift_unit
  import shf_pkg::*;
#(
  parameter int W  = 16,
  parameter int RW = 4,
  parameter int CW = 6
) (
  input  logic [3:0]    op_code,
  input  logic [RW-1:0] reg_idx,
  input  logic [CW-1:0] count,
  input  logic          clr_req,
  input  logic [W-1:0]  opnd_hi,
  input  logic [W-1:0]  opnd_lo,
  output logic [W-1:0]  res_hi,
  output logic [W-1:0]  res_lo,
  output logic          wr_hi,
  output logic          wr_lo,
  output logic [RW-1:0] pair_idx,
  output logic          cnt_err
);
  localparam int SAW = $clog2(W) + 1;
  localparam int DAW = $clog2(2 * W) + 1;

  logic          eff_dbl;
  logic          eff_left;
  fill_e         eff_fill;
  logic [CW-1:0] eff_amt;
  logic          rng_err;
  logic [W-1:0]  single_res;
  logic [2*W-1:0] double_res;

  always_comb begin
    if (clr_req) begin
      eff_dbl  = 1'b0;
      eff_left = 1'b0;
      eff_fill = FILL_ZERO;
      eff_amt  = CW'(W);
    end else begin
      eff_dbl  = op_code[OP_DBL_BIT];
      eff_left = op_code[OP_DIR_BIT];
      eff_fill = fill_e'(op_code[1:0]);
      eff_amt  = count;
    end
  end

  shf_range_chk #(.W(W), .CW(CW)) u_rng (
    .dbl (eff_dbl),
    .amt (eff_amt),
    .err (rng_err)
  );

  shf_pair_idx #(.RW(RW)) u_pair (
    .base_idx (reg_idx),
    .next_idx (pair_idx)
  );

  shf_core #(.DW(W)) u_single (
    .val  (opnd_hi),
    .amt  (eff_amt[SAW-1:0]),
    .left (eff_left),
    .fill (eff_fill),
    .res  (single_res)
  );

  shf_core #(.DW(2 * W)) u_double (
    .val  ({opnd_hi, opnd_lo}),
    .amt  (eff_amt[DAW-1:0]),
    .left (eff_left),
    .fill (eff_fill),
    .res  (double_res)
  );

  always_comb begin
    cnt_err = rng_err;
    if (rng_err) begin
      res_hi = opnd_hi;
      res_lo = opnd_lo;
      wr_hi  = 1'b0;
      wr_lo  = 1'b0;
    end else if (eff_dbl) begin
      res_hi = double_res[2*W-1:W];
      res_lo = double_res[W-1:0];
      wr_hi  = 1'b1;
      wr_lo  = 1'b1;
    end else begin
      res_hi = single_res;
      res_lo = opnd_lo;
      wr_hi  = 1'b1;
      wr_lo  = 1'b0;
    end
  end
endmodule

// File: tb/reg_shift_unit_test.sv
module reg_shift_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] hi;
    logic [15:0] lo;
    logic        whi;
    logic        wlo;
    logic [3:0]  pidx;
    logic        err;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic [3:0]  reg_idx = '0;
  logic [5:0]  count = '0;
  logic        clr_req = 1'b0;
  logic [15:0] opnd_hi = '0;
  logic [15:0] opnd_lo = '0;
  logic [15:0] res_hi, res_lo;
  logic        wr_hi, wr_lo, cnt_err;
  logic [3:0]  pair_idx;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_shift_unit uut (
    .op_code (op_code), .reg_idx (reg_idx), .count (count),
    .clr_req (clr_req), .opnd_hi (opnd_hi), .opnd_lo (opnd_lo),
    .res_hi (res_hi), .res_lo (res_lo), .wr_hi (wr_hi), .wr_lo (wr_lo),
    .pair_idx (pair_idx), .cnt_err (cnt_err)
  );

  // Bit-at-a-time reference shifter, written from the requirements.
  function automatic logic [31:0] ref_shift(input logic [31:0] v0, input int w,
                                            input bit lft, input logic [1:0] f, input int n);
    logic [31:0] v = v0;
    logic [31:0] nv;
    logic fb;
    for (int s = 0; s < n; s++) begin
      nv = v;
      if (lft) begin
        case (f)
          2'b00: fb = 1'b0;
          2'b01: fb = 1'b1;
          2'b10: fb = v0[0];
          default: fb = v[w-1];
        endcase
        for (int i = w-1; i > 0; i--) nv[i] = v[i-1];
        nv[0] = fb;
      end else begin
        case (f)
          2'b00: fb = 1'b0;
          2'b01: fb = 1'b1;
          2'b10: fb = v0[w-1];
          default: fb = v[0];
        endcase
        for (int i = 0; i < w-1; i++) nv[i] = v[i+1];
        nv[w-1] = fb;
      end
      v = nv;
    end
    return v;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [3:0] ri, input logic [5:0] cnt,
                       input logic clr, input logic [15:0] a, input logic [15:0] b,
                       input string tag);
    exp_t e;
    bit dbl, bad;
    int lim;
    logic [31:0] r;
    dbl = clr ? 1'b0 : op[2];
    lim = dbl ? 32 : 16;
    bad = clr ? 1'b0 : (cnt == 0 || int'(cnt) > lim);
    e.pidx = ri + 4'd1;
    e.tag = tag;
    e.err = bad;
    if (clr) begin
      e.hi = 16'h0; e.lo = b; e.whi = 1'b1; e.wlo = 1'b0;
    end else if (bad) begin
      e.hi = a; e.lo = b; e.whi = 1'b0; e.wlo = 1'b0;
    end else if (dbl) begin
      r = ref_shift({a, b}, 32, op[3], op[1:0], int'(cnt));
      e.hi = r[31:16]; e.lo = r[15:0]; e.whi = 1'b1; e.wlo = 1'b1;
    end else begin
      r = ref_shift({16'h0, a}, 16, op[3], op[1:0], int'(cnt));
      e.hi = r[15:0]; e.lo = b; e.whi = 1'b1; e.wlo = 1'b0;
    end
    @(posedge clk);
    op_code = op; reg_idx = ri; count = cnt; clr_req = clr;
    opnd_hi = a; opnd_lo = b;
    sb.push_back(e);
  endtask

  // Monitor: compares away from the driving edge (R11: same-cycle result).
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (res_hi !== e.hi || res_lo !== e.lo || wr_hi !== e.whi ||
          wr_lo !== e.wlo || pair_idx !== e.pidx || cnt_err !== e.err) begin
        fails++;
        $display("FAIL %s: got hi=%h lo=%h whi=%b wlo=%b pidx=%0d err=%b exp hi=%h lo=%h whi=%b wlo=%b pidx=%0d err=%b",
                 e.tag, res_hi, res_lo, wr_hi, wr_lo, pair_idx, cnt_err,
                 e.hi, e.lo, e.whi, e.wlo, e.pidx, e.err);
      end
    end
  end

  initial begin
    logic [31:0] lf = 32'hACE1_2468;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Idle inputs: count 0 is illegal, nothing written (R8)
    drive(4'h0, 4'd0, 6'd0, 1'b0, 16'h0, 16'h0, "R8 idle count zero");
    // R2 zero fill
    drive(4'b0000, 4'd3, 6'd4, 1'b0, 16'h8001, 16'h1234, "R2 right zero");
    drive(4'b1000, 4'd3, 6'd4, 1'b0, 16'h8001, 16'h1234, "R2 left zero");
    drive(4'b0000, 4'd3, 6'd16, 1'b0, 16'hFFFF, 16'h1234, "R2 shift16 clears");
    // R3 one fill
    drive(4'b0001, 4'd2, 6'd3, 1'b0, 16'h0100, 16'h0, "R3 right one");
    drive(4'b1001, 4'd2, 6'd5, 1'b0, 16'h0100, 16'h0, "R3 left one");
    // R4 extend both directions
    drive(4'b0010, 4'd1, 6'd4, 1'b0, 16'h8000, 16'h0, "R4 right extend msb");
    drive(4'b1010, 4'd1, 6'd4, 1'b0, 16'h8001, 16'h0, "R4 left extend lsb");
    drive(4'b1010, 4'd1, 6'd4, 1'b0, 16'h7FFE, 16'h0, "R4 left extend lsb zero");
    // R5 circular
    drive(4'b0011, 4'd0, 6'd1, 1'b0, 16'h0001, 16'h0, "R5 right rotate");
    drive(4'b1011, 4'd0, 6'd16, 1'b0, 16'hA5C3, 16'h0, "R5 rotate full single");
    drive(4'b0111, 4'd0, 6'd32, 1'b0, 16'h1357, 16'h9BDF, "R5 rotate full double");
    // R6 double word, R1 width bit
    drive(4'b0100, 4'd5, 6'd20, 1'b0, 16'hF00F, 16'h1234, "R6 double right zero");
    drive(4'b1110, 4'd5, 6'd17, 1'b0, 16'h0001, 16'h0003, "R6 double left extend");
    drive(4'b0111, 4'd5, 6'd8, 1'b0, 16'h00AB, 16'hCD00, "R6 double rotate");
    // R7 wrap
    drive(4'b0100, 4'd15, 6'd1, 1'b0, 16'h0002, 16'h0001, "R7 pair wraps 15->0");
    drive(4'b0000, 4'd14, 6'd1, 1'b0, 16'h0002, 16'h0001, "R7 pair 14->15");
    // R8 ranges
    drive(4'b0000, 4'd2, 6'd17, 1'b0, 16'h1111, 16'h2222, "R8 single 17 illegal");
    drive(4'b0100, 4'd2, 6'd33, 1'b0, 16'h1111, 16'h2222, "R8 double 33 illegal");
    drive(4'b0100, 4'd2, 6'd0, 1'b0, 16'h1111, 16'h2222, "R8 double 0 illegal");
    drive(4'b0101, 4'd2, 6'd32, 1'b0, 16'h1111, 16'h2222, "R8 double 32 legal");
    drive(4'b1011, 4'd2, 6'd63, 1'b0, 16'h1111, 16'h2222, "R8 count 63 illegal");
    // R9 single writes high only
    drive(4'b1000, 4'd9, 6'd1, 1'b0, 16'h4000, 16'hBEEF, "R9 single keeps lo");
    // R10 clear ignores op and count
    drive(4'b1111, 4'd6, 6'd0, 1'b1, 16'hFFFF, 16'h5555, "R10 clear with bad count");
    drive(4'b0101, 4'd6, 6'd40, 1'b1, 16'h1234, 16'h5555, "R10 clear double op");
    // R1 sweep of all sixteen operations under pseudo-random data
    for (int k = 0; k < 160; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[3:0], lf[7:4], 6'((lf[13:8] % 34)), 1'b0, lf[31:16], lf[23:8] ^ 16'h5A5A,
            "R1 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule